// File: doc/BRIEF.md
# Vector Element Loop Stepper

This block tracks where a vector operation stands in its element loop. It has a source side and a destination side. Each side holds a main element step and, inside it, a sub-element step. Every advance strobe moves both sides one sub-element forward. The sub-step is the inner loop and runs from 0 up to the sub-vector length setting. After that the main step moves on and the sub-step wraps to 0. A per-side enable lets one side stall while the other moves, so the two sides can drift apart.

The loop finishes at the first advance in which either side sits on its final position, judged from the registered step values. That advance raises the end flag, and the next cycle all four counters are back at zero. Two cases also end the loop at once. A scalar operation ends it on its only advance. A zero vector length ends it and leaves the counters where they were. When compare-record is enabled, every advance also yields a 4-bit condition field. That field holds the end flag together with the inverted loop-end bits of the selected shape.

Top module: `vec_elem_stepper`

## Requirements
- R1: After rst_ni is released, all four step counters read 0, and end_o, cr_o and cr_valid_o are 0.
- R2: On an advance where the side's enable is high, the loop does not end, and the side's sub-step is not equal to subvl_i, the sub-step increments by 1 and the main step holds.
- R3: On such an advance where the sub-step equals subvl_i (and the loop does not end), the main step increments by 1 and the sub-step returns to 0 in the same cycle.
- R4: A side is at its end-point when its sub-step equals subvl_i and its main step equals vl_i-1. An advance while either side is at its end-point raises end_o in that cycle. On the next cycle all four counters are 0.
- R5: A side whose enable input is low keeps both of its counters on an advance that does not end the loop. The end test still looks at both sides.
- R6: loop_rst_i clears all four counters on the next cycle. It takes priority over advance_i, so end_o and cr_valid_o stay 0 in that cycle.
- R7: An advance with is_vector_i=0 and vl_i nonzero raises end_o and clears all counters on the next cycle.
- R8: An advance with vl_i=0 raises end_o and leaves all four counters unchanged.
- R9: cr_valid_o equals advance_i & rc_en_i & ~loop_rst_i. When it is high, cr_o[3:1] is the bitwise inverse of shape_ends_i[3*shape_sel_i +: 3] and cr_o[0] equals end_o. When it is low, cr_o is 0.
- R10: end_o is 0 in any cycle without an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vl_i | input | 7 | Vector length |
| subvl_i | input | 2 | Last sub-step index (sub-elements minus one) |
| is_vector_i | input | 1 | 1 for a vector operation, 0 for scalar |
| advance_i | input | 1 | Step-advance strobe |
| loop_rst_i | input | 1 | Loop-reset strobe |
| src_en_i | input | 1 | Source side may move on this advance |
| dst_en_i | input | 1 | Destination side may move on this advance |
| rc_en_i | input | 1 | Compare-record enable |
| shape_sel_i | input | 2 | Active shape index |
| shape_ends_i | input | 12 | Loop-end bits, 3 per shape, shape k at [3k+:3] |
| src_step_o | output | 7 | Source main step |
| src_sub_o | output | 2 | Source sub-step |
| dst_step_o | output | 7 | Destination main step |
| dst_sub_o | output | 2 | Destination sub-step |
| end_o | output | 1 | Loop end reached on this advance |
| cr_o | output | 4 | Condition field |
| cr_valid_o | output | 1 | Condition field is valid |

## Verification
Two things can land on the same edge. One is a loop-reset strobe arriving together with an advance. The other is an end-point advance arriving while the sides stand at different positions. The bench drives the reset strobe during an advance that would otherwise end the loop or move a counter. It expects zero counters, with end_o and cr_valid_o held low. The bench also stalls the destination side on a repeating pattern, so the source reaches its end-point first. It then checks that this single advance ends the loop and clears both sides, including the stalled one that was mid-loop.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  localparam int STEP_W     = 7;
  localparam int SUB_W      = 2;
  localparam int COND_W     = 4;
  localparam int NUM_SHAPES = 4;
  localparam int END_W      = COND_W - 1;
  localparam int SEL_W      = $clog2(NUM_SHAPES);

  typedef struct packed {
    logic src_end;
    logic dst_end;
  } side_end_t;
endpackage

// File: rtl/vstep_side.sv
module vstep_side #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [SUB_W-1:0]  subvl_i,
  input  logic              adv_i,
  input  logic              clr_i,
  output logic [STEP_W-1:0] step_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              at_end_o
);
  logic [STEP_W-1:0] step_q;
  logic [SUB_W-1:0]  sub_q;
  logic              last_sub, last_step;

  assign last_sub  = (sub_q == subvl_i);
  assign last_step = (step_q == vl_i - STEP_W'(1));
  assign at_end_o  = last_sub & last_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      sub_q  <= '0;
    end else if (clr_i) begin
      step_q <= '0;
      sub_q  <= '0;
    end else if (adv_i && !at_end_o) begin
      if (last_sub) begin
        step_q <= step_q + STEP_W'(1);
        sub_q  <= '0;
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  assign step_o = step_q;
  assign sub_o  = sub_q;

  assert_sub_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !at_end_o && !last_sub) |=>
      (sub_q == $past(sub_q) + SUB_W'(1)) && (step_q == $past(step_q)));

  assert_step_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !at_end_o && last_sub) |=>
      (step_q == $past(step_q) + STEP_W'(1)) && (sub_q == '0));

  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(step_q) && $stable(sub_q));
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
#(
  parameter int STEP_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] vl_i,
  input  logic              is_vector_i,
  input  logic              advance_i,
  input  logic              loop_rst_i,
  input  logic              src_en_i,
  input  logic              dst_en_i,
  input  side_end_t         ends_i,
  output logic              adv_src_o,
  output logic              adv_dst_o,
  output logic              clr_o,
  output logic              end_o,
  output logic              step_ok_o
);
  logic vl_zero, live, hit;

  assign vl_zero   = (vl_i == '0);
  assign live      = advance_i & ~loop_rst_i;
  // either side's end-point ends the loop
  assign hit       = ends_i.src_end | ends_i.dst_end;
  assign end_o     = live & (vl_zero | ~is_vector_i | hit);
  assign clr_o     = loop_rst_i | (end_o & ~vl_zero);
  assign adv_src_o = live & ~end_o & src_en_i;
  assign adv_dst_o = live & ~end_o & dst_en_i;
  assign step_ok_o = live;

  assert_quiet_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |-> !end_o);

  assert_rst_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_rst_i |-> !end_o && !adv_src_o && !adv_dst_o);
endmodule

// File: rtl/vstep_cond.sv
module vstep_cond
  import vstep_pkg::*;
#(
  parameter int NSHAPE = 4,
  parameter int EW     = 3,
  localparam int SW    = (NSHAPE > 1) ? $clog2(NSHAPE) : 1
) (
  input  logic                 rc_en_i,
  input  logic                 step_ok_i,
  input  logic                 end_i,
  input  logic [SW-1:0]        sel_i,
  input  logic [NSHAPE*EW-1:0] ends_flat_i,
  output logic [EW:0]          cr_o,
  output logic                 cr_valid_o
);
  logic [EW-1:0] ends_arr [NSHAPE];

  for (genvar k = 0; k < NSHAPE; k++) begin : g_shape
    assign ends_arr[k] = ends_flat_i[k*EW +: EW];
  end

  assign cr_valid_o = rc_en_i & step_ok_i;
  assign cr_o       = cr_valid_o ? {~ends_arr[sel_i], end_i} : '0;
endmodule

// File: rtl/vec_elem_stepper.sv
module vec_elem_stepper
  import vstep_pkg::*;
#(
  parameter int SW_STEP = STEP_W,
  parameter int SW_SUB  = SUB_W,
  parameter int NSHAPE  = NUM_SHAPES,
  localparam int EW     = END_W,
  localparam int SLW    = SEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SW_STEP-1:0]   vl_i,
  input  logic [SW_SUB-1:0]    subvl_i,
  input  logic                 is_vector_i,
  input  logic                 advance_i,
  input  logic                 loop_rst_i,
  input  logic                 src_en_i,
  input  logic                 dst_en_i,
  input  logic                 rc_en_i,
  input  logic [SLW-1:0]       shape_sel_i,
  input  logic [NSHAPE*EW-1:0] shape_ends_i,
  output logic [SW_STEP-1:0]   src_step_o,
  output logic [SW_SUB-1:0]    src_sub_o,
  output logic [SW_STEP-1:0]   dst_step_o,
  output logic [SW_SUB-1:0]    dst_sub_o,
  output logic                 end_o,
  output logic [EW:0]          cr_o,
  output logic                 cr_valid_o
);
  side_end_t ends;
  logic      adv_src, adv_dst, clr, step_ok;
  logic      adv_side [2];
  logic [SW_STEP-1:0] step_side [2];
  logic [SW_SUB-1:0]  sub_side  [2];
  logic               end_side  [2];

  assign adv_side[0] = adv_src;
  assign adv_side[1] = adv_dst;

  for (genvar s = 0; s < 2; s++) begin : g_side
    vstep_side #(.STEP_W(SW_STEP), .SUB_W(SW_SUB)) u_side (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vl_i     (vl_i),
      .subvl_i  (subvl_i),
      .adv_i    (adv_side[s]),
      .clr_i    (clr),
      .step_o   (step_side[s]),
      .sub_o    (sub_side[s]),
      .at_end_o (end_side[s])
    );
  end

  assign ends.src_end = end_side[0];
  assign ends.dst_end = end_side[1];

  vstep_ctrl #(.STEP_W(SW_STEP)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vl_i        (vl_i),
    .is_vector_i (is_vector_i),
    .advance_i   (advance_i),
    .loop_rst_i  (loop_rst_i),
    .src_en_i    (src_en_i),
    .dst_en_i    (dst_en_i),
    .ends_i      (ends),
    .adv_src_o   (adv_src),
    .adv_dst_o   (adv_dst),
    .clr_o       (clr),
    .end_o       (end_o),
    .step_ok_o   (step_ok)
  );

  vstep_cond #(.NSHAPE(NSHAPE), .EW(EW)) u_cond (
    .rc_en_i     (rc_en_i),
    .step_ok_i   (step_ok),
    .end_i       (end_o),
    .sel_i       (shape_sel_i),
    .ends_flat_i (shape_ends_i),
    .cr_o        (cr_o),
    .cr_valid_o  (cr_valid_o)
  );

  assign src_step_o = step_side[0];
  assign src_sub_o  = sub_side[0];
  assign dst_step_o = step_side[1];
  assign dst_sub_o  = sub_side[1];

  assert_end_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && vl_i != '0) |=>
      (src_step_o == '0) && (src_sub_o == '0) && (dst_step_o == '0) && (dst_sub_o == '0));

  assert_loop_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_rst_i |=>
      (src_step_o == '0) && (src_sub_o == '0) && (dst_step_o == '0) && (dst_sub_o == '0));

  assert_zero_vl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !loop_rst_i && vl_i == '0) |=>
      $stable(src_step_o) && $stable(src_sub_o) && $stable(dst_step_o) && $stable(dst_sub_o));

  assert_cond_end_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> (cr_o[0] == end_o));

  assert_scalar_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !loop_rst_i && !is_vector_i) |-> end_o);
endmodule

// File: tb/sim_vec_elem_stepper.sv
module sim_vec_elem_stepper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  vl_i = '0;
  logic [1:0]  subvl_i = '0;
  logic        is_vector_i = 1'b1;
  logic        advance_i = 1'b0;
  logic        loop_rst_i = 1'b0;
  logic        src_en_i = 1'b1;
  logic        dst_en_i = 1'b1;
  logic        rc_en_i = 1'b0;
  logic [1:0]  shape_sel_i = '0;
  logic [11:0] shape_ends_i = 12'h5A3;
  logic [6:0]  src_step_o, dst_step_o;
  logic [1:0]  src_sub_o, dst_sub_o;
  logic        end_o, cr_valid_o;
  logic [3:0]  cr_o;

  int n_chk = 0;
  int n_err = 0;
  int m_ss = 0, m_su = 0, m_ds = 0, m_du = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  vec_elem_stepper u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ctr(input string req);
    chk({req, " src_step"}, src_step_o, m_ss);
    chk({req, " src_sub"},  src_sub_o,  m_su);
    chk({req, " dst_step"}, dst_step_o, m_ds);
    chk({req, " dst_sub"},  dst_sub_o,  m_du);
  endtask

  // one cycle: drive at negedge, check combinational outputs, clock, check counters
  task automatic cyc(input bit adv, input bit lrst, input bit es, input bit ed,
                     input string req, output bit e_end);
    int vl, sv, ev;
    bit endt, exp_v;
    @(negedge clk_i);
    advance_i = adv; loop_rst_i = lrst; src_en_i = es; dst_en_i = ed;
    #1;
    vl = vl_i; sv = subvl_i;
    endt = (m_su == sv && m_ss == vl - 1) || (m_du == sv && m_ds == vl - 1);
    e_end = adv && !lrst && (vl == 0 || !is_vector_i || endt);
    chk({req, " R10/R4 end_o"}, end_o, e_end);
    exp_v = adv && rc_en_i && !lrst;
    chk({req, " R9 cr_valid"}, cr_valid_o, exp_v);
    ev = exp_v ? ({~shape_ends_i[shape_sel_i*3 +: 3], e_end}) & 15 : 0;
    chk({req, " R9 cr"}, cr_o, ev);
    @(posedge clk_i);
    if (lrst) begin
      m_ss = 0; m_su = 0; m_ds = 0; m_du = 0;
    end else if (adv) begin
      if (vl == 0) begin
      end else if (e_end) begin
        m_ss = 0; m_su = 0; m_ds = 0; m_du = 0;
      end else begin
        if (es) begin
          if (m_su == sv) begin m_ss++; m_su = 0; end else m_su++;
        end
        if (ed) begin
          if (m_du == sv) begin m_ds++; m_du = 0; end else m_du++;
        end
      end
    end
    #1;
    chk_ctr({req, " R2/R3/R5 ctr"});
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit e;
    #20;
    chk("R1 end_o", end_o, 0);
    chk("R1 cr_valid", cr_valid_o, 0);
    chk_ctr("R1 rst");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 cr_o", cr_o, 0);
    chk_ctr("R1 after release");

    // sweep lengths; dst stalls on a pattern, sides drift apart
    for (int vl = 1; vl <= 6; vl++) begin
      for (int sv = 0; sv < 4; sv++) begin
        vl_i = 7'(vl); subvl_i = 2'(sv); is_vector_i = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, "R6 pre", e);
        for (int k = 0; k < 400; k++) begin
          rc_en_i = k[0];
          shape_sel_i = 2'(k % 4);
          shape_ends_i = 12'(12'h5A3 ^ (vl * 37 + k));
          cyc((k % 5) != 4, 1'b0, 1'b1, ((k + sv) % 3) != 0, "R2/R3/R4/R5 sweep", e);
          if (e) break;
        end
        chk("R4 loop ended", int'(e), 1);
      end
    end

    // reset strobe collides with an end-point advance
    vl_i = 7'd2; subvl_i = 2'd0; rc_en_i = 1'b1;
    cyc(1'b0, 1'b1, 1'b1, 1'b1, "R6 pre", e);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, "R3", e);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, "R6 collide", e);
    chk("R6 no end on collide", int'(e), 0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, "R3 src only", e);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, "R6 collide mid", e);

    // scalar op
    vl_i = 7'd5; subvl_i = 2'd3;
    cyc(1'b1, 1'b0, 1'b1, 1'b1, "R2 pre scalar", e);
    is_vector_i = 1'b0;
    cyc(1'b1, 1'b0, 1'b1, 1'b1, "R7 scalar", e);
    chk("R7 end_o", int'(e), 1);
    is_vector_i = 1'b1;

    // zero vl holds counters
    cyc(1'b1, 1'b0, 1'b1, 1'b1, "R2 pre vl0", e);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, "R5 dst only", e);
    vl_i = 7'd0;
    cyc(1'b1, 1'b0, 1'b1, 1'b1, "R8 vl0", e);
    chk("R8 end_o", int'(e), 1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, "R10 idle", e);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule